// File: doc/BRIEF.md
# Wiegand Credential Frame Transmitter

This block sends one card credential as a Wiegand-style two-wire frame. A frame is either 26 bits long (24 data bits) or 34 bits long (32 data bits). Each frame has a parity bit in front of the data and a parity bit after it. The front bit covers the upper half of the payload. The rear bit covers the lower half. The block computes both parity bits itself and sends the frame most-significant bit first. Every bit is one high pulse: a 1 pulses the "one" line and a 0 pulses the "zero" line. A fixed low interval separates each pulse from the next.

Two line pairs are provided, a primary pair and an alternate pair. A channel input chooses which pair carries the frame, and the other pair stays low. Pulse width and interval are given in nanoseconds and turned into clock-cycle counts from the clock-frequency parameter. The defaults (50 µs pulse, 2 ms interval) can therefore be shortened for simulation. A request is a one-cycle `start` while `busy` is low. `busy` covers the whole frame, and `done` pulses once at the end.

Top module: `wieg_frame_tx`

## Requirements
- R1: With `fmt_long`=1 a frame has 34 bits, and with `fmt_long`=0 it has 26 bits. Exactly that many pulses are sent before `done`.
- R2: The first bit sent is the even parity of the upper data half (`data_in[31:16]` in 34-bit mode, `data_in[23:12]` in 26-bit mode). It is 1 when that half holds an odd number of ones.
- R3: The last bit sent is the odd parity of the lower data half (`data_in[15:0]` or `data_in[11:0]`). It is 1 when that half holds an even number of ones.
- R4: Bits leave in this order: front parity, then the data bits from the highest index down to bit 0, then rear parity.
- R5: A 1 is a high pulse on the selected pair's one-line, and a 0 is a high pulse on its zero-line. All lines rest low, and no line is high while `busy` is low.
- R6: Every pulse stays high for exactly PULSE_CYC clock cycles. The first pulse rises in the cycle after the edge that accepts `start`.
- R7: Consecutive pulses of a frame are separated by exactly GAP_CYC low cycles.
- R8: `chan_sel`=0 selects the primary pair (`pri_zero`/`pri_one`) and `chan_sel`=1 selects the alternate pair (`alt_zero`/`alt_one`). The unselected pair stays low for the whole frame.
- R9: `data_in`, `fmt_long` and `chan_sel` are captured at the edge where `start` is high and `busy` is low. A `start` or input change while `busy` is high has no effect on the frame in progress.
- R10: `busy` rises in the cycle after start is accepted. `done` is high for exactly one cycle, GAP_CYC cycles after the last pulse falls, and `busy` is low in the following cycle.
- R11: In 26-bit mode `data_in[31:24]` has no effect on the frame.
- R12: During and right after reset all four lines, `busy` and `done` are low.
- R13: The two lines of a pair are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Send request, accepted while busy is low |
| fmt_long | input | 1 | 1: 34-bit frame, 0: 26-bit frame |
| chan_sel | input | 1 | 0: primary pair, 1: alternate pair |
| data_in | input | 32 | Credential payload |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame strobe |
| pri_zero | output | 1 | Primary pair, zero line |
| pri_one | output | 1 | Primary pair, one line |
| alt_zero | output | 1 | Alternate pair, zero line |
| alt_one | output | 1 | Alternate pair, one line |

## Verification
The edge that accepts `start` is counted as cycle 0. Pulse k of an n-bit frame then rises at cycle k·(PULSE_CYC+GAP_CYC)+1 and stays high for PULSE_CYC cycles. `done` appears at cycle n·(PULSE_CYC+GAP_CYC)+1, and `busy` is low one cycle later. The bench samples on falling clock edges. A driver task counts cycles from the accepting edge to `done` and compares the count with that formula. A monitor measures each pulse width and each low gap in cycles, and checks each pulse against the bit that the driver queued from its own parity computation.

// File: rtl/wft_pkg.sv
// Package wft_pkg
// Shared constants and the sequencing state type for the Wiegand frame
// transmitter. Assumes a 32-bit payload; the long frame adds two parity bits.
package wft_pkg;
    localparam int DATA_W  = 32;
    localparam int FRAME_W = DATA_W + 2;
    localparam int SHORT_W = 24;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PULSE,
        ST_GAP,
        ST_DONE
    } wft_state_e;
endpackage

// File: rtl/wft_frame_build.sv
// Module wft_frame_build
// Combinational frame assembly. Computes the front even parity over the upper
// payload half and the rear odd parity over the lower half, then places the
// frame left-aligned so the first bit to send sits at the top. Assumes
// SHORT_W is even and smaller than DATA_W.
module wft_frame_build #(
    parameter int DATA_W  = 32,
    parameter int SHORT_W = 24,
    localparam int FRAME_W = DATA_W + 2,
    localparam int NB_W    = $clog2(FRAME_W + 1)
) (
    input  logic [DATA_W-1:0]  data_in,
    input  logic               fmt_long,
    output logic [FRAME_W-1:0] frame,
    output logic [NB_W-1:0]    nbits
);
    localparam int HALF_L = DATA_W / 2;
    localparam int HALF_S = SHORT_W / 2;
    localparam int PAD_W  = FRAME_W - SHORT_W - 2;

    logic lead_l, rear_l, lead_s, rear_s;

    // Parity of each half, for both formats.
    always_comb begin
        lead_l = ^data_in[DATA_W-1:HALF_L];
        rear_l = ~^data_in[HALF_L-1:0];
        lead_s = ^data_in[SHORT_W-1:HALF_S];
        rear_s = ~^data_in[HALF_S-1:0];
    end

    // Left-aligned frame and its length for the selected format.
    always_comb begin
        if (fmt_long) begin
            frame = {lead_l, data_in, rear_l};
            nbits = NB_W'(FRAME_W);
        end else begin
            frame = {lead_s, data_in[SHORT_W-1:0], rear_s, {PAD_W{1'b0}}};
            nbits = NB_W'(SHORT_W + 2);
        end
    end
endmodule

// File: rtl/wft_phase_timer.sv
// Module wft_phase_timer
// Cycle counter for the pulse and gap phases. It counts while run is high and
// flags the final cycle of the current phase. It restarts from zero at every
// phase end. Assumes both phase lengths are at least one cycle.
module wft_phase_timer #(
    parameter int PULSE_CYC = 4,
    parameter int GAP_CYC   = 10,
    localparam int MAX_CYC  = (PULSE_CYC > GAP_CYC) ? PULSE_CYC : GAP_CYC,
    localparam int CW       = $clog2(MAX_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic in_pulse,
    output logic phase_end
);
    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    // Last count value of the current phase.
    always_comb begin
        lim       = in_pulse ? CW'(PULSE_CYC - 1) : CW'(GAP_CYC - 1);
        phase_end = run && (cnt == lim);
    end

    // Phase counter, cleared when idle or at a phase boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt <= '0;
        else if (!run || phase_end) cnt <= '0;
        else                       cnt <= cnt + 1'b1;
    end

    // The count never passes the length of the active phase (R6, R7).
    assert_cnt_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= lim));
endmodule

// File: rtl/wft_line_router.sv
// Module wft_line_router
// Steers the current bit onto the one-line or zero-line of the selected pair.
// Assumes drive is high only during a pulse phase.
module wft_line_router (
    input  logic drive,
    input  logic bit_val,
    input  logic chan,
    output logic pri_zero,
    output logic pri_one,
    output logic alt_zero,
    output logic alt_one
);
    // Decode pair and line from channel and bit value.
    always_comb begin
        pri_one  = drive &  bit_val & ~chan;
        pri_zero = drive & ~bit_val & ~chan;
        alt_one  = drive &  bit_val &  chan;
        alt_zero = drive & ~bit_val &  chan;
    end
endmodule

// File: rtl/wieg_frame_tx.sv
// Module wieg_frame_tx
// Top level of the Wiegand frame transmitter. Captures payload, format and
// channel on an accepted start. Then it plays the frame bit by bit as a
// pulse followed by a gap, and strobes done after the last gap. Pulse and
// gap lengths come from CLK_HZ and the nanosecond parameters, and each is
// at least one cycle.
module wieg_frame_tx #(
    parameter int CLK_HZ   = 200_000_000,
    parameter int PULSE_NS = 50_000,
    parameter int GAP_NS   = 2_000_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        fmt_long,
    input  logic        chan_sel,
    input  logic [31:0] data_in,
    output logic        busy,
    output logic        done,
    output logic        pri_zero,
    output logic        pri_one,
    output logic        alt_zero,
    output logic        alt_one
);
    import wft_pkg::*;

    localparam longint PULSE_L   = (longint'(CLK_HZ) * longint'(PULSE_NS)) / 64'd1_000_000_000;
    localparam longint GAP_L     = (longint'(CLK_HZ) * longint'(GAP_NS)) / 64'd1_000_000_000;
    localparam int     PULSE_CYC = (PULSE_L < 1) ? 1 : int'(PULSE_L);
    localparam int     GAP_CYC   = (GAP_L < 1) ? 1 : int'(GAP_L);
    localparam int     NB_W      = $clog2(FRAME_W + 1);

    wft_state_e         state;
    logic [FRAME_W-1:0] shreg;
    logic [NB_W-1:0]    left;
    logic               chan_q;
    logic [FRAME_W-1:0] frame_c;
    logic [NB_W-1:0]    nbits_c;
    logic               phase_end;
    logic               run;

    wft_frame_build #(.DATA_W(DATA_W), .SHORT_W(SHORT_W)) u_build (
        .data_in (data_in),
        .fmt_long(fmt_long),
        .frame   (frame_c),
        .nbits   (nbits_c)
    );

    assign run = (state == ST_PULSE) || (state == ST_GAP);

    wft_phase_timer #(.PULSE_CYC(PULSE_CYC), .GAP_CYC(GAP_CYC)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .in_pulse (state == ST_PULSE),
        .phase_end(phase_end)
    );

    wft_line_router u_route (
        .drive   (state == ST_PULSE),
        .bit_val (shreg[FRAME_W-1]),
        .chan    (chan_q),
        .pri_zero(pri_zero),
        .pri_one (pri_one),
        .alt_zero(alt_zero),
        .alt_one (alt_one)
    );

    // Frame sequencer: capture, pulse, gap, next bit, end strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            shreg  <= '0;
            left   <= '0;
            chan_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    shreg  <= frame_c;
                    left   <= nbits_c;
                    chan_q <= chan_sel;
                    state  <= ST_PULSE;
                end
                ST_PULSE: if (phase_end) state <= ST_GAP;
                ST_GAP: if (phase_end) begin
                    if (left == NB_W'(1)) begin
                        state <= ST_DONE;
                    end else begin
                        shreg <= shreg << 1;
                        left  <= left - 1'b1;
                        state <= ST_PULSE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Handshake outputs decoded from the sequencer state.
    always_comb begin
        busy = (state != ST_IDLE);
        done = (state == ST_DONE);
    end

    assert_pair_excl_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !(pri_zero && pri_one) && !(alt_zero && alt_one));

    assert_idle_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_q ? !(pri_zero || pri_one) : !(alt_zero || alt_one)));

    assert_lines_need_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pri_zero || pri_one || alt_zero || alt_one) |-> busy);

    assert_busy_rises_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!busy && !done));

    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> $stable(chan_q));

    assert_left_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> ((left != '0) && (left <= NB_W'(FRAME_W))));
endmodule

// File: tb/wieg_frame_tx_tb.sv
// Scoreboard bench for wieg_frame_tx. The driver queues the bits it expects
// from its own parity computation, and the monitor pops and compares each one
// as a pulse appears. Pulse width and gap are measured in cycles.
module wieg_frame_tx_tb;
    localparam int EXP_P = 4;    // 20 ns at 200 MHz
    localparam int EXP_G = 10;   // 50 ns at 200 MHz

    typedef struct packed {
        logic       ch;
        logic       b;
        logic [5:0] pos;
        logic [5:0] n;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        fmt_long = 1'b0;
    logic        chan_sel = 1'b0;
    logic [31:0] data_in = '0;
    logic        busy, done, pri_zero, pri_one, alt_zero, alt_one;

    int   checks = 0;
    int   failures = 0;
    int   cyc = 0;
    exp_t sbq[$];

    always #2.5 clk = ~clk;

    wieg_frame_tx #(.CLK_HZ(200_000_000), .PULSE_NS(20), .GAP_NS(50)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .fmt_long(fmt_long),
        .chan_sel(chan_sel), .data_in(data_in), .busy(busy), .done(done),
        .pri_zero(pri_zero), .pri_one(pri_one), .alt_zero(alt_zero), .alt_one(alt_one)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            check(1'b0, "watchdog", cyc, 150000);
            finish_run();
        end
    end

    // Monitor: pops expected bits on each rising pulse and times pulses and gaps.
    logic prev_any = 1'b0;
    bit   in_gap = 1'b0;
    int   hi_cnt = 0;
    int   gap_cnt = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            logic [3:0] lines, expl;
            exp_t e;
            string tag;
            lines = {alt_one, alt_zero, pri_one, pri_zero};
            if ((pri_zero && pri_one) || (alt_zero && alt_one))
                check(1'b0, "R13 both lines high", int'(lines), 0);
            if ((|lines) && !prev_any) begin
                if (sbq.size() == 0) begin
                    check(1'b0, "R1 unexpected extra pulse", int'(lines), 0);
                end else begin
                    e = sbq.pop_front();
                    expl = e.ch ? {e.b, !e.b, 2'b00} : {2'b00, e.b, !e.b};
                    if (e.pos == 0) tag = "R2 front parity (R5/R8 lines)";
                    else if (e.pos == e.n - 1) tag = "R3 rear parity (R5/R8 lines)";
                    else tag = "R4 data bit order (R5/R8 lines)";
                    check(lines == expl, tag, int'(lines), int'(expl));
                end
                if (in_gap) check(gap_cnt == EXP_G, "R7 gap cycles", gap_cnt, EXP_G);
                hi_cnt = 1;
                in_gap = 1'b0;
            end else if (|lines) begin
                hi_cnt++;
            end else if (prev_any) begin
                check(hi_cnt == EXP_P, "R6 pulse width", hi_cnt, EXP_P);
                gap_cnt = 1;
                in_gap = 1'b1;
            end else if (in_gap) begin
                gap_cnt++;
            end
            if (done) in_gap = 1'b0;
            prev_any = |lines;
        end
    end

    // Driver: queue the expected frame, launch it, and time busy and done.
    task automatic send(input logic [31:0] d, input logic fl, input logic ch, input bit meddle);
        int n, dw, c1, c2, k, exp_k;
        exp_t e;
        n = fl ? 34 : 26;
        dw = fl ? 32 : 24;
        c1 = 0; c2 = 0;
        for (int i = dw - 1; i >= dw / 2; i--) c1 += int'(d[i]);
        for (int i = dw / 2 - 1; i >= 0; i--) c2 += int'(d[i]);
        e.ch = ch; e.n = 6'(n);
        e.pos = 0; e.b = (c1 % 2 == 1); sbq.push_back(e);
        for (int i = dw - 1; i >= 0; i--) begin
            e.pos = 6'(dw - i); e.b = d[i]; sbq.push_back(e);
        end
        e.pos = 6'(n - 1); e.b = (c2 % 2 == 0); sbq.push_back(e);

        @(negedge clk);
        data_in = d; fmt_long = fl; chan_sel = ch; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        k = 1;
        check(busy == 1'b1, "R10 busy after start", int'(busy), 1);
        while (!done) begin
            @(negedge clk);
            k++;
            if (meddle && k >= 20 && k < 24) begin
                // R9: start and new inputs mid-frame must be ignored
                start = 1'b1; data_in = ~d; fmt_long = ~fl; chan_sel = ~ch;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        exp_k = n * (EXP_P + EXP_G) + 1;
        check(k == exp_k, "R10 done cycle", k, exp_k);
        check(sbq.size() == 0, "R1 all bits sent at done", sbq.size(), 0);
        @(negedge clk);
        check(!busy && !done, "R10 busy low after done", int'({busy, done}), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12: reset state
        check({busy, done, pri_zero, pri_one, alt_zero, alt_one} == 6'b0,
              "R12 reset outputs", int'({busy, done, pri_zero, pri_one, alt_zero, alt_one}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({busy, done, pri_zero, pri_one, alt_zero, alt_one} == 6'b0,
              "R12 after reset", int'({busy, done, pri_zero, pri_one, alt_zero, alt_one}), 0);
        send(32'h00AB_CDEF, 1'b0, 1'b0, 1'b0);  // R1 26-bit, primary pair (R8)
        send(32'hDEAD_BEEF, 1'b1, 1'b1, 1'b0);  // R1 34-bit, alternate pair (R8)
        send(32'hFF00_0000, 1'b0, 1'b1, 1'b0);  // R11 upper byte ignored, R3 rear=1
        send(32'h5A00_0FFF, 1'b0, 1'b0, 1'b0);  // R11 with mixed halves
        send(32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0);  // R2 front=0, R3 rear=1
        send(32'h0001_0001, 1'b1, 1'b1, 1'b0);  // R2 front=1, R3 rear=0
        send(32'h0000_0000, 1'b1, 1'b0, 1'b0);  // all zeros, 34-bit
        send(32'h1234_5678, 1'b1, 1'b0, 1'b1);  // R9 start ignored while busy
        send(32'h00F0_0F0F, 1'b0, 1'b1, 1'b1);  // R9 in 26-bit mode
        repeat (5) @(negedge clk);
        check(sbq.size() == 0, "R5 no stray pulses", sbq.size(), 0);
        finish_run();
    end
endmodule